// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulator

This block rebuilds the three interrupt sources of a real-time clock in logic: the once-per-second update event, the time-of-day alarm and the periodic event. It is driven by a single polling tick, which is the match strobe of a free-running tick counter's comparator. It also reads the current hours, minutes and seconds from the clock. Enable and mask strobes switch each source on or off. Load strobes capture the alarm time and the periodic rate. On each serviced tick the block can raise a one-cycle interrupt pulse. That pulse comes with a 16-bit flag word naming the sources that fired.

The polling rate is 64 Hz. When the periodic source is enabled at a rate above 64 Hz, the polling rate rises to that rate. The block also works out the next comparator value for the tick counter and presents it with a load strobe. Each reload is the previous comparator value plus one tick interval, so the ticks do not drift. The tick interval is the number of counter clocks per second shifted right by the base-2 log of the polling rate. When the first source is enabled while all sources are off, the schedule restarts from the live counter value.

Top module: `rtc_irq_emulator`

## Requirements
- R1: After reset `irq`, `irq_flags` and `cmp_load` are 0 and `cmp_next` is 0. All three sources are off and the periodic rate code is 6 (64 Hz).
- R2: The polling rate log2 T is the periodic rate code k when the periodic source is on and k > 6, and 6 otherwise. A reload step is `CLK_PER_SEC >> T`.
- R3: While the periodic source is on, each serviced tick increments a count. When the count reaches 2^(T-k), bit 6 of the flags is set and the count returns to 0.
- R4: The periodic count is cleared when the periodic source is enabled and when a rate code is loaded. A clear in the same cycle as a tick overrides that tick's update of the count.
- R5: The update source sets flag bit 4 on a serviced tick when `cur_sec` differs from the last recorded seconds value. That value is then recorded. The recorded value is 0 after reset and changes only when the update source fires.
- R6: The alarm source sets flag bit 5 on a serviced tick only when hours, minutes and seconds all equal the loaded alarm time.
- R7: One cycle after a serviced tick on which a source fires, `irq` pulses for one cycle. At the same time `irq_flags` holds 0x01 in bits 15:8, bit 7 set, and the bits of the firing sources. In every other cycle `irq_flags` is 0.
- R8: A tick that arrives while any source is on is serviced. One cycle later `cmp_load` pulses and `cmp_next` becomes its previous value plus the step of R2, using the state before the tick.
- R9: A tick arriving while all sources are off changes no output. An enable strobe applied while all are off makes `cmp_next` equal to `cnt_now` plus the step computed with the new state, and pulses `cmp_load` one cycle later.
- R10: Enable and mask strobes take effect from the next cycle's tick, and a masked source never sets its flag. If a source gets both strobes in one cycle, enable wins.
- R11: A loaded rate code below 1 is stored as 1, and a code above 13 is stored as 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick | input | 1 | polling tick strobe from the comparator match |
| cur_hr | input | 5 | current hours |
| cur_min | input | 6 | current minutes |
| cur_sec | input | 6 | current seconds |
| cnt_now | input | 32 | live value of the tick counter |
| en_set | input | 3 | enable strobes: bit0 update, bit1 periodic, bit2 alarm |
| en_clr | input | 3 | mask strobes, same bit order |
| alm_load | input | 1 | capture the alarm time |
| alm_hr | input | 5 | alarm hours |
| alm_min | input | 6 | alarm minutes |
| alm_sec | input | 6 | alarm seconds |
| rate_load | input | 1 | capture the periodic rate code |
| rate_code | input | 4 | periodic rate as log2 of Hz (1 to 13) |
| irq | output | 1 | interrupt pulse |
| irq_flags | output | 16 | count 15:8, request 7, periodic 6, alarm 5, update 4 |
| cmp_load | output | 1 | strobe: load `cmp_next` into the comparator |
| cmp_next | output | 32 | next comparator value |

## Verification
The assertions check four things on every cycle. An interrupt appears only after a tick. The flag word is well-formed while `irq` is high and zero otherwise. A flag is never set for a source that was off. Every tick-driven reload advances the comparator by exactly one power-of-two step, and no reload happens without a tick or an enable. The bench's behavioural model covers what a single-cycle property cannot: the divide-by-ratio cadence of the periodic source, the switch to a faster polling rate, the seconds-change and alarm-match conditions, the restart from the live counter, and rate-code clamping.

// File: rtl/rtc_irq_emulator.sv
module rtc_irq_emulator #(
  parameter int CNT_W       = 32,
  parameter int CLK_PER_SEC = 1048576,
  parameter int BASE_LOG2   = 6,
  parameter int MIN_LOG2    = 1,
  parameter int MAX_LOG2    = 13,
  parameter int PCNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [4:0]        cur_hr,
  input  logic [5:0]        cur_min,
  input  logic [5:0]        cur_sec,
  input  logic [CNT_W-1:0]  cnt_now,
  input  logic [2:0]        en_set,
  input  logic [2:0]        en_clr,
  input  logic              alm_load,
  input  logic [4:0]        alm_hr,
  input  logic [5:0]        alm_min,
  input  logic [5:0]        alm_sec,
  input  logic              rate_load,
  input  logic [3:0]        rate_code,
  output logic              irq,
  output logic [15:0]       irq_flags,
  output logic              cmp_load,
  output logic [CNT_W-1:0]  cmp_next
);
  localparam int RATE_W = 4;

  logic              uie_on, pie_on, aie_on;
  logic [RATE_W-1:0] rate_k;
  logic [PCNT_W-1:0] pcnt;
  logic [5:0]        prev_sec;
  logic [4:0]        a_hr;
  logic [5:0]        a_min, a_sec;

  function automatic logic [RATE_W-1:0] tick_log2(input logic pie, input logic [RATE_W-1:0] k);
    return (pie && k > RATE_W'(BASE_LOG2)) ? k : RATE_W'(BASE_LOG2);
  endfunction

  wire any_on = uie_on | pie_on | aie_on;
  wire uie_nx = (uie_on & ~en_clr[0]) | en_set[0];
  wire pie_nx = (pie_on & ~en_clr[1]) | en_set[1];
  wire aie_nx = (aie_on & ~en_clr[2]) | en_set[2];

  wire [RATE_W-1:0] code_clamped =
    (rate_code < RATE_W'(MIN_LOG2)) ? RATE_W'(MIN_LOG2) :
    (rate_code > RATE_W'(MAX_LOG2)) ? RATE_W'(MAX_LOG2) : rate_code;
  wire [RATE_W-1:0] rate_k_nx = rate_load ? code_clamped : rate_k;

  wire [RATE_W-1:0] cur_t = tick_log2(pie_on, rate_k);
  wire [RATE_W-1:0] new_t = tick_log2(pie_nx, rate_k_nx);
  wire [CNT_W-1:0]  cur_step = CNT_W'(CLK_PER_SEC) >> cur_t;
  wire [CNT_W-1:0]  new_step = CNT_W'(CLK_PER_SEC) >> new_t;
  wire [PCNT_W-1:0] ratio = PCNT_W'(1) << (cur_t - rate_k);

  wire serve    = tick & any_on;
  wire restart  = ~any_on & (|en_set);
  wire fire_per = pie_on && ({1'b0, pcnt} + 1'b1 >= {1'b0, ratio});
  wire fire_upd = uie_on && (cur_sec != prev_sec);
  wire fire_alm = aie_on && (cur_hr == a_hr) && (cur_min == a_min) && (cur_sec == a_sec);
  wire fired    = fire_per | fire_upd | fire_alm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uie_on    <= 1'b0;
      pie_on    <= 1'b0;
      aie_on    <= 1'b0;
      rate_k    <= RATE_W'(BASE_LOG2);
      pcnt      <= '0;
      prev_sec  <= '0;
      a_hr      <= '0;
      a_min     <= '0;
      a_sec     <= '0;
      irq       <= 1'b0;
      irq_flags <= '0;
      cmp_load  <= 1'b0;
      cmp_next  <= '0;
    end else begin
      uie_on   <= uie_nx;
      pie_on   <= pie_nx;
      aie_on   <= aie_nx;
      rate_k   <= rate_k_nx;
      irq      <= serve & fired;
      irq_flags <= (serve & fired) ? {8'd1, 1'b1, fire_per, fire_alm, fire_upd, 4'b0000} : 16'h0000;
      cmp_load <= serve | restart;
      if (restart)
        cmp_next <= cnt_now + new_step;
      else if (serve)
        cmp_next <= cmp_next + cur_step;
      if (en_set[1] | rate_load)
        pcnt <= '0;
      else if (serve & pie_on)
        pcnt <= fire_per ? '0 : pcnt + 1'b1;
      if (serve & fire_upd)
        prev_sec <= cur_sec;
      if (alm_load) begin
        a_hr  <= alm_hr;
        a_min <= alm_min;
        a_sec <= alm_sec;
      end
    end
  end
endmodule

// File: rtl/rtc_irq_emulator_chk.sv
module rtc_irq_emulator_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [2:0]       en_set,
  input logic             irq,
  input logic [15:0]      irq_flags,
  input logic             cmp_load,
  input logic [CNT_W-1:0] cmp_next,
  input logic             uie_on,
  input logic             pie_on,
  input logic             aie_on
);
  p_irq_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> !irq);

  p_flag_format_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_flags[15:8] == 8'd1 && irq_flags[7] && (|irq_flags[6:4]) && irq_flags[3:0] == 4'd0));

  p_flags_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> irq_flags == 16'h0000);

  p_update_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_flags[4]) |-> $past(uie_on));

  p_periodic_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_flags[6]) |-> $past(pie_on));

  p_alarm_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_flags[5]) |-> $past(aie_on));

  p_reload_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_load && $past(tick) && $past(uie_on | pie_on | aie_on))
      |-> $countones(cmp_next - $past(cmp_next)) == 1);

  p_reload_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_load |-> ($past(tick) || $past(|en_set)));
endmodule

bind rtc_irq_emulator rtc_irq_emulator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .en_set(en_set),
  .irq(irq), .irq_flags(irq_flags), .cmp_load(cmp_load), .cmp_next(cmp_next),
  .uie_on(uie_on), .pie_on(pie_on), .aie_on(aie_on)
);

// File: tb/test_rtc_irq_emulator.sv
module test_rtc_irq_emulator;
  localparam int CLK_PERIOD = 10;
  localparam int CPS = 1048576;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [4:0] cur_hr = 0, alm_hr = 0;
  logic [5:0] cur_min = 0, cur_sec = 0, alm_min = 0, alm_sec = 0;
  logic [31:0] cnt_now = 0;
  logic [2:0] en_set = 0, en_clr = 0;
  logic alm_load = 0, rate_load = 0;
  logic [3:0] rate_code = 0;
  logic irq, cmp_load;
  logic [15:0] irq_flags;
  logic [31:0] cmp_next;

  rtc_irq_emulator i_rtc_irq_emulator (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_hr(cur_hr), .cur_min(cur_min),
    .cur_sec(cur_sec), .cnt_now(cnt_now), .en_set(en_set), .en_clr(en_clr),
    .alm_load(alm_load), .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
    .rate_load(rate_load), .rate_code(rate_code), .irq(irq), .irq_flags(irq_flags),
    .cmp_load(cmp_load), .cmp_next(cmp_next));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string phase = "R1 reset";

  bit m_u, m_p, m_a;
  int m_k, m_cnt, m_prev, m_ah, m_am, m_as;
  logic [31:0] m_cmp;
  bit m_irq, m_load;
  logic [15:0] m_flags;
  int per_fires = 0, upd_fires = 0, alm_fires = 0, irqs = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_u = 0; m_p = 0; m_a = 0; m_k = 6; m_cnt = 0; m_prev = 0;
      m_ah = 0; m_am = 0; m_as = 0; m_cmp = 0; m_irq = 0; m_load = 0; m_flags = 0;
    end else begin
      bit any;
      int t, f;
      any = m_u | m_p | m_a;
      t = (m_p && m_k > 6) ? m_k : 6;
      m_irq = 0; m_load = 0; m_flags = 0; f = 0;
      if (tick && any) begin
        m_cmp = m_cmp + 32'(CPS >> t);
        m_load = 1;
        if (m_u && int'(cur_sec) != m_prev) begin f = f | 16; m_prev = int'(cur_sec); end
        if (m_p) begin
          m_cnt++;
          if (m_cnt >= (1 << t) / (1 << m_k)) begin f = f | 64; m_cnt = 0; end
        end
        if (m_a && int'(cur_hr) == m_ah && int'(cur_min) == m_am && int'(cur_sec) == m_as) f = f | 32;
        if (f != 0) begin m_irq = 1; m_flags = 16'(f | 128 | 256); end
      end
      if (en_clr[0]) m_u = 0;
      if (en_clr[1]) m_p = 0;
      if (en_clr[2]) m_a = 0;
      if (en_set[0]) m_u = 1;
      if (en_set[1]) begin m_p = 1; m_cnt = 0; end
      if (en_set[2]) m_a = 1;
      if (rate_load) begin
        m_k = int'(rate_code);
        if (m_k < 1) m_k = 1;
        if (m_k > 13) m_k = 13;
        m_cnt = 0;
      end
      if (!any && en_set != 0) begin
        t = (m_p && m_k > 6) ? m_k : 6;
        m_cmp = cnt_now + 32'(CPS >> t);
        m_load = 1;
      end
      if (alm_load) begin m_ah = int'(alm_hr); m_am = int'(alm_min); m_as = int'(alm_sec); end
    end
  end

  always @(negedge clk) if (!finished) begin
    vectors++;
    if (irq !== m_irq || irq_flags !== m_flags || cmp_load !== m_load || cmp_next !== m_cmp) begin
      miscompares++;
      $display("FAIL %s: irq=%b flags=%h load=%b next=%h expected irq=%b flags=%h load=%b next=%h",
               phase, irq, irq_flags, cmp_load, cmp_next, m_irq, m_flags, m_load, m_cmp);
    end
    if (irq) begin
      irqs++;
      if (irq_flags[6]) per_fires++;
      if (irq_flags[5]) alm_fires++;
      if (irq_flags[4]) upd_fires++;
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_tick(int gap);
    tick = 1; step(1); tick = 0; step(gap);
  endtask

  task automatic strobe_set(logic [2:0] s);
    en_set = s; step(1); en_set = 0; step(1);
  endtask

  task automatic strobe_clr(logic [2:0] c);
    en_clr = c; step(1); en_clr = 0; step(1);
  endtask

  task automatic load_rate(logic [3:0] c);
    rate_code = c; rate_load = 1; step(1); rate_load = 0; step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    check("R1 irq after reset", int'(irq), 0);
    check("R1 cmp_next after reset", int'(cmp_next), 0);

    phase = "R9 idle ticks";
    for (int i = 0; i < 3; i++) pulse_tick(2);
    check("R9 no reload while idle", int'(cmp_next), 0);

    phase = "R9 restart from counter";
    cnt_now = 32'd1000;
    en_set = 3'b001; step(1); en_set = 0;
    check("R9 restart value", int'(cmp_next), 1000 + (CPS >> 6));
    step(1);

    phase = "R5 update on seconds change";
    upd_fires = 0;
    for (int s = 0; s < 4; s++) begin
      cur_sec = 6'(s);
      pulse_tick(1);
      pulse_tick(1);
    end
    check("R5 update fire count", upd_fires, 3);
    check("R8 drift-free reload", int'(cmp_next), 1000 + 9 * (CPS >> 6));

    phase = "R3 periodic at 4 Hz";
    load_rate(4'd2);
    strobe_set(3'b010);
    per_fires = 0;
    for (int i = 0; i < 32; i++) pulse_tick(1);
    check("R3 periodic ratio 16", per_fires, 2);

    phase = "R4 count cleared by rate load";
    for (int i = 0; i < 10; i++) pulse_tick(1);
    load_rate(4'd2);
    per_fires = 0;
    for (int i = 0; i < 15; i++) pulse_tick(1);
    check("R4 no fire before 16 after clear", per_fires, 0);
    pulse_tick(1);
    check("R4 fire on 16th after clear", per_fires, 1);

    phase = "R2 fast periodic 256 Hz";
    load_rate(4'd8);
    per_fires = 0;
    for (int i = 0; i < 5; i++) pulse_tick(1);
    check("R2 fire every tick", per_fires, 5);

    phase = "R4 tick with enable strobe";
    load_rate(4'd5);
    for (int i = 0; i < 3; i++) pulse_tick(1);
    tick = 1; en_set = 3'b010; step(1); tick = 0; en_set = 0; step(1);
    for (int i = 0; i < 3; i++) pulse_tick(1);

    phase = "R6 alarm match";
    alm_hr = 5'd7; alm_min = 6'd30; alm_sec = 6'd15;
    alm_load = 1; step(1); alm_load = 0; step(1);
    strobe_clr(3'b011);
    strobe_set(3'b100);
    alm_fires = 0;
    cur_hr = 5'd7; cur_min = 6'd30; cur_sec = 6'd14; pulse_tick(1);
    cur_hr = 5'd6; cur_sec = 6'd15; pulse_tick(1);
    cur_hr = 5'd7; cur_min = 6'd31; pulse_tick(1);
    cur_min = 6'd30; pulse_tick(1);
    check("R6 single alarm match", alm_fires, 1);

    phase = "R10 masked sources";
    strobe_clr(3'b111);
    irqs = 0;
    for (int i = 0; i < 4; i++) begin cur_sec = 6'(20 + i); pulse_tick(1); end
    check("R10 no irq when masked", irqs, 0);

    phase = "R10 set wins over clear";
    cnt_now = 32'd5000;
    en_set = 3'b001; en_clr = 3'b001; step(1); en_set = 0; en_clr = 0; step(1);
    upd_fires = 0;
    cur_sec = 6'd40; pulse_tick(1);
    check("R10 update still enabled", upd_fires, 1);
    strobe_clr(3'b001);

    phase = "R11 rate clamp low";
    load_rate(4'd0);
    cnt_now = 32'd0;
    strobe_set(3'b010);
    per_fires = 0;
    for (int i = 0; i < 64; i++) pulse_tick(1);
    check("R11 code 0 acts as 2 Hz", per_fires, 2);
    strobe_clr(3'b010);

    phase = "R11 rate clamp high";
    load_rate(4'd15);
    cnt_now = 32'd0;
    en_set = 3'b010; step(1); en_set = 0;
    check("R11 code 15 gives 8192 Hz step", int'(cmp_next), CPS >> 13);
    step(1);
    pulse_tick(1);
    pulse_tick(1);
    strobe_clr(3'b010);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule